// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Unit

This block delivers the two source operands that the decode stage of a five-stage, 32-bit in-order pipeline needs. It contains a 32-entry register file. The writeback stage writes that file through its one write port. The block also watches the results moving through the three stages ahead of decode: execute, memory and writeback.

Each source register number is compared with the destination number of each of those three stages, which makes six comparisons in total. When a stage will write the register that decode is reading, the operand is taken from that stage's result and not from the register file, which still holds the older value. Because the operands are already current in decode, a branch comparator placed in decode sees correct data. A stage whose destination is register 0 never forwards. Instructions that write nothing, such as a plain jump, carry destination 0, so they can never overtake a real value.

The operand outputs are combinational from the source numbers, the stage fields and the register file contents. Load-use stalls are handled elsewhere.

Top module: `byp_decode_bypass`

## Requirements
- R1: After reset is released, every register reads as zero on both operand outputs, provided no stage is forwarding.
- R2: When `wb_we` is 1 and `wb_rd` is not 0 at a rising clock edge, `wb_data` is stored in register `wb_rd`. From the next cycle, a read of that register with no stage forwarding returns that value.
- R3: When `wb_we` is 0, the register file is left unchanged, whatever `wb_rd` and `wb_data` hold.
- R4: If `ex_we` is 1, `ex_rd` is not 0 and `ex_rd` equals the source number, the operand equals `ex_data`.
- R5: If execute does not match but memory does (`mem_we` is 1, `mem_rd` is not 0 and `mem_rd` equals the source number), the operand equals `mem_data`.
- R6: If neither execute nor memory matches but writeback does, the operand equals `wb_data`. This also holds in the very cycle in which that same value is being written into the register file.
- R7: When several stages match, execute wins over memory, and memory wins over writeback.
- R8: A stage whose write flag is 0 never forwards, even when its destination equals the source number.
- R9: Register 0 always reads as zero. A destination of 0 never forwards, even when the stage's write flag is 1. A writeback to register 0 has no effect.
- R10: The two operands are resolved independently. Each uses its own source number (`rs_a` for `opnd_a`, `rs_b` for `opnd_b`), and both may name the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears the register file |
| rs_a | input | 5 | Source register number for operand A |
| rs_b | input | 5 | Source register number for operand B |
| ex_we | input | 1 | Execute-stage instruction writes a register |
| ex_rd | input | 5 | Execute-stage destination register number |
| ex_data | input | 32 | Execute-stage result |
| mem_we | input | 1 | Memory-stage instruction writes a register |
| mem_rd | input | 5 | Memory-stage destination register number |
| mem_data | input | 32 | Memory-stage result |
| wb_we | input | 1 | Writeback write enable, also the writeback forward qualifier |
| wb_rd | input | 5 | Writeback destination register number |
| wb_data | input | 32 | Writeback result, written into the register file |
| opnd_a | output | 32 | Resolved operand A |
| opnd_b | output | 32 | Resolved operand B |

## Verification
The properties assume the following about the inputs:
- All source and stage fields are known values at every rising edge.
- The writeback triple is the only path into the register file.
- The state a property looks back to is taken from cycles after reset was released.

The stimulus changes every input only on the falling edge, so each rising edge samples settled values. It draws register numbers from a narrow range so that one-, two- and three-way matches and destination-0 cases occur often. It also drives full-width random data, so that a value taken from the wrong source cannot match the expected one by chance.

// File: rtl/byp_pkg.sv
package byp_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int AW     = $clog2(NREG);
    localparam int NSTAGE = 3;   // index 0 = execute (youngest), 1 = memory, 2 = writeback
    localparam int NRD    = 2;   // read ports in decode

    typedef struct packed {
        logic            we;
        logic [AW-1:0]   rd;
        logic [XLEN-1:0] data;
    } stage_t;

    typedef struct packed {
        logic [NREG-1:0][XLEN-1:0] mem;
    } rf_state_t;
endpackage

// File: rtl/byp_regfile.sv
module byp_regfile
    import byp_pkg::*;
#(
    parameter int W    = XLEN,
    parameter int N    = NREG,
    parameter int A    = AW,
    parameter int NR   = NRD
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [A-1:0]         wr_addr,
    input  logic [W-1:0]         wr_data,
    input  logic [NR-1:0][A-1:0] rd_addr,
    output logic [NR-1:0][W-1:0] rd_data
);
    typedef struct packed {
        logic [N-1:0][W-1:0] mem;
    } state_t;

    state_t st_d, st_q;

    // next-state process: writes to entry 0 are discarded
    always_comb begin
        st_d = st_q;
        if (wr_en && (wr_addr != '0)) begin
            st_d.mem[wr_addr] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NR; g++) begin : g_rd
        assign rd_data[g] = (rd_addr[g] == '0) ? '0 : st_q.mem[rd_addr[g]];
    end
endmodule

// File: rtl/byp_fwd_sel.sv
module byp_fwd_sel
    import byp_pkg::*;
#(
    parameter int NS = NSTAGE
) (
    input  logic [AW-1:0]       src,
    input  logic [XLEN-1:0]     rf_val,
    input  stage_t [NS-1:0]     stg,
    output logic [XLEN-1:0]     opnd
);
    logic [NS-1:0] hit;

    // one comparator per older stage; destination 0 is never a candidate
    for (genvar g = 0; g < NS; g++) begin : g_cmp
        assign hit[g] = stg[g].we && (stg[g].rd != '0) && (stg[g].rd == src);
    end

    // walk oldest to youngest so the youngest hit is applied last
    always_comb begin
        opnd = rf_val;
        for (int i = NS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                opnd = stg[i].data;
            end
        end
    end
endmodule

// File: rtl/byp_decode_bypass.sv
module byp_decode_bypass
    import byp_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rs_a,
    input  logic [AW-1:0]   rs_b,
    input  logic            ex_we,
    input  logic [AW-1:0]   ex_rd,
    input  logic [XLEN-1:0] ex_data,
    input  logic            mem_we,
    input  logic [AW-1:0]   mem_rd,
    input  logic [XLEN-1:0] mem_data,
    input  logic            wb_we,
    input  logic [AW-1:0]   wb_rd,
    input  logic [XLEN-1:0] wb_data,
    output logic [XLEN-1:0] opnd_a,
    output logic [XLEN-1:0] opnd_b
);
    stage_t [NSTAGE-1:0]          stages;
    logic   [NRD-1:0][AW-1:0]     src;
    logic   [NRD-1:0][XLEN-1:0]   rf_val;
    logic   [NRD-1:0][XLEN-1:0]   resolved;

    assign stages[0] = '{we: ex_we,  rd: ex_rd,  data: ex_data};
    assign stages[1] = '{we: mem_we, rd: mem_rd, data: mem_data};
    assign stages[2] = '{we: wb_we,  rd: wb_rd,  data: wb_data};

    assign src[0] = rs_a;
    assign src[1] = rs_b;

    byp_regfile #(
        .W  (XLEN),
        .N  (NREG),
        .A  (AW),
        .NR (NRD)
    ) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wb_we),
        .wr_addr (wb_rd),
        .wr_data (wb_data),
        .rd_addr (src),
        .rd_data (rf_val)
    );

    for (genvar g = 0; g < NRD; g++) begin : g_port
        byp_fwd_sel #(
            .NS (NSTAGE)
        ) u_sel (
            .src    (src[g]),
            .rf_val (rf_val[g]),
            .stg    (stages),
            .opnd   (resolved[g])
        );
    end

    assign opnd_a = resolved[0];
    assign opnd_b = resolved[1];
endmodule

// File: rtl/byp_checker.sv
module byp_checker
    import byp_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic [AW-1:0]   rs_a,
    input logic [AW-1:0]   rs_b,
    input logic            ex_we,
    input logic [AW-1:0]   ex_rd,
    input logic [XLEN-1:0] ex_data,
    input logic            mem_we,
    input logic [AW-1:0]   mem_rd,
    input logic [XLEN-1:0] mem_data,
    input logic            wb_we,
    input logic [AW-1:0]   wb_rd,
    input logic [XLEN-1:0] wb_data,
    input logic [XLEN-1:0] opnd_a,
    input logic [XLEN-1:0] opnd_b
);
    logic live_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    logic ex_a, mem_a, wb_a, ex_b, mem_b, wb_b, any_a;
    assign ex_a  = ex_we  && (ex_rd  != '0) && (ex_rd  == rs_a);
    assign mem_a = mem_we && (mem_rd != '0) && (mem_rd == rs_a);
    assign wb_a  = wb_we  && (wb_rd  != '0) && (wb_rd  == rs_a);
    assign ex_b  = ex_we  && (ex_rd  != '0) && (ex_rd  == rs_b);
    assign mem_b = mem_we && (mem_rd != '0) && (mem_rd == rs_b);
    assign wb_b  = wb_we  && (wb_rd  != '0) && (wb_rd  == rs_b);
    assign any_a = ex_a || mem_a || wb_a;

    a_r4_ex_fwd_a: assert property (@(posedge clk) disable iff (!rst_n)
        ex_a |-> opnd_a == ex_data);
    a_r10_ex_fwd_b: assert property (@(posedge clk) disable iff (!rst_n)
        ex_b |-> opnd_b == ex_data);
    a_r5_mem_fwd_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_a && mem_a) |-> opnd_a == mem_data);
    a_r6_wb_fwd_a: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_a && !mem_a && wb_a) |-> opnd_a == wb_data);
    a_r7_prio_b: assert property (@(posedge clk) disable iff (!rst_n)
        (!ex_b && mem_b && wb_b) |-> opnd_b == mem_data);
    a_r9_zero_a: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_a == '0) |-> opnd_a == '0);
    a_r9_zero_b: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_b == '0) |-> opnd_b == '0);
    a_r2_write_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(wb_we) && ($past(wb_rd) != '0) && (rs_a == $past(wb_rd)) && !any_a)
        |-> opnd_a == $past(wb_data));
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && (rs_a == $past(rs_a)) && !any_a && !$past(any_a)
         && !($past(wb_we) && ($past(wb_rd) == rs_a)))
        |-> opnd_a == $past(opnd_a));
endmodule

bind byp_decode_bypass byp_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rs_a     (rs_a),
    .rs_b     (rs_b),
    .ex_we    (ex_we),
    .ex_rd    (ex_rd),
    .ex_data  (ex_data),
    .mem_we   (mem_we),
    .mem_rd   (mem_rd),
    .mem_data (mem_data),
    .wb_we    (wb_we),
    .wb_rd    (wb_rd),
    .wb_data  (wb_data),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b)
);

// File: tb/byp_decode_bypass_tb.sv
module byp_decode_bypass_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rs_a = '0, rs_b = '0;
    logic        ex_we = 1'b0, mem_we = 1'b0, wb_we = 1'b0;
    logic [4:0]  ex_rd = '0, mem_rd = '0, wb_rd = '0;
    logic [31:0] ex_data = '0, mem_data = '0, wb_data = '0;
    logic [31:0] opnd_a, opnd_b;

    always #(CLK_PERIOD/2) clk = ~clk;

    byp_decode_bypass dut_i (
        .clk(clk), .rst_n(rst_n), .rs_a(rs_a), .rs_b(rs_b),
        .ex_we(ex_we), .ex_rd(ex_rd), .ex_data(ex_data),
        .mem_we(mem_we), .mem_rd(mem_rd), .mem_data(mem_data),
        .wb_we(wb_we), .wb_rd(wb_rd), .wb_data(wb_data),
        .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    typedef struct {
        logic [31:0] exp_a;
        logic [31:0] exp_b;
        string       tag;
    } item_t;

    item_t       sb_q[$];
    logic [31:0] model_rf [32];
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    // expected operand from the requirements: R9 zero, R7 ex>mem>wb, R8 write flag, else stored value
    function automatic logic [31:0] expect_val(input logic [4:0] rs);
        if (rs == 5'd0)                                 return 32'd0;
        if (ex_we  && ex_rd  != 5'd0 && ex_rd  == rs)   return ex_data;
        if (mem_we && mem_rd != 5'd0 && mem_rd == rs)   return mem_data;
        if (wb_we  && wb_rd  != 5'd0 && wb_rd  == rs)   return wb_data;
        return model_rf[rs];
    endfunction

    task automatic drive(input logic [4:0] a, input logic [4:0] b,
                         input logic ew, input logic [4:0] er, input logic [31:0] ed,
                         input logic mw, input logic [4:0] mr, input logic [31:0] md,
                         input logic ww, input logic [4:0] wr, input logic [31:0] wd,
                         input string tag);
        item_t it;
        @(negedge clk);
        rs_a = a; rs_b = b;
        ex_we = ew; ex_rd = er; ex_data = ed;
        mem_we = mw; mem_rd = mr; mem_data = md;
        wb_we = ww; wb_rd = wr; wb_data = wd;
        it.exp_a = expect_val(a);
        it.exp_b = expect_val(b);
        it.tag   = tag;
        sb_q.push_back(it);
        if (ww && wr != 5'd0) model_rf[wr] = wd;  // R2: visible from the next cycle
    endtask

    task automatic rd_only(input logic [4:0] a, input logic [4:0] b, input string tag);
        drive(a, b, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // monitor: compares a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            if (sb_q.size() != 0) begin
                item_t it;
                it = sb_q.pop_front();
                n_checks += 2;
                if (opnd_a !== it.exp_a) begin
                    n_errors++;
                    $display("FAIL %s opnd_a actual=%08h expected=%08h", it.tag, opnd_a, it.exp_a);
                end
                if (opnd_b !== it.exp_b) begin
                    n_errors++;
                    $display("FAIL %s opnd_b actual=%08h expected=%08h", it.tag, opnd_b, it.exp_b);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 32; i++) model_rf[i] = 32'd0;
        // writes attempted during reset must not land
        wb_we = 1'b1; wb_rd = 5'd3; wb_data = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        wb_we = 1'b0;
        rst_n = 1'b1;

        // R1: reset state of every entry, both ports
        for (int i = 0; i < 32; i++) rd_only(i[4:0], 5'(31 - i), "R1");

        // R2: fill every register through writeback, then read back
        for (int i = 1; i < 32; i++) drive(0, 0, 0, 0, 0, 0, 0, 0, 1, i[4:0], 32'hA500_0000 + i, "R2");
        for (int i = 0; i < 32; i++) rd_only(i[4:0], i[4:0], "R2 R10");

        // R3: write disabled leaves the entry alone
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 5'd5, 32'h1234_5678, "R3");
        rd_only(5'd5, 5'd6, "R3");

        // R9: writeback to register 0 ignored; destination 0 never forwards
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 5'd0, 32'hFFFF_FFFF, "R9");
        rd_only(5'd0, 5'd0, "R9");
        drive(0, 5'd0, 1, 5'd0, 32'h1111_1111, 1, 5'd0, 32'h2222_2222, 1, 5'd0, 32'h3333_3333, "R9");

        // R4 / R5 / R6 single stage forwards
        drive(5'd7, 5'd8, 1, 5'd7, 32'hE0E0_0007, 0, 0, 0, 0, 0, 0, "R4");
        drive(5'd9, 5'd7, 0, 0, 0, 1, 5'd9, 32'hB0B0_0009, 0, 0, 0, "R5");
        drive(5'd10, 5'd11, 0, 0, 0, 0, 0, 0, 1, 5'd10, 32'hC0C0_000A, "R6");
        rd_only(5'd10, 5'd10, "R2 R6");

        // R7 priority with two and three matches
        drive(5'd12, 5'd12, 1, 5'd12, 32'h0E0E_000C, 1, 5'd12, 32'h0D0D_000C, 1, 5'd12, 32'h0C0C_000C, "R7");
        drive(5'd13, 5'd14, 0, 0, 0, 1, 5'd13, 32'h0D0D_000D, 1, 5'd13, 32'h0C0C_000D, "R7");

        // R8 write flag low in each stage
        drive(5'd15, 5'd16, 0, 5'd15, 32'h5555_5555, 0, 5'd16, 32'h6666_6666, 0, 5'd15, 32'h7777_7777, "R8");
        drive(5'd17, 5'd17, 0, 5'd17, 32'h5555_0000, 1, 5'd17, 32'h6666_0000, 0, 0, 0, "R8");

        // R10 different stages feed each port in the same cycle
        drive(5'd18, 5'd19, 1, 5'd18, 32'hAAAA_0018, 1, 5'd19, 32'hBBBB_0019, 0, 0, 0, "R10");

        // mixed traffic with narrow register numbers to provoke matches
        for (int n = 0; n < 400; n++) begin
            drive(5'($urandom_range(0, 7)), 5'($urandom_range(0, 7)),
                  1'($urandom), 5'($urandom_range(0, 7)), $urandom,
                  1'($urandom), 5'($urandom_range(0, 7)), $urandom,
                  1'($urandom), 5'($urandom_range(0, 7)), $urandom,
                  "R4 R5 R6 R7 R8 mix");
        end

        rd_only(0, 0, "R9");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule